// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Unit

This unit sits next to a memory read path protected by single-error-correct, double-error-detect coding. The ECC decoder sends it one-cycle pulses for correctable and uncorrectable errors, together with the failing address, the 64-bit read word and the 8-bit syndrome. The unit keeps one capture record for each error class, raises a level interrupt while any error flag is pending, and clears flags when software writes them back to an acknowledge register.

Each class is tracked by its own four-state machine. `REC_CLEAR` means no flag is set. `REC_HELD` means the first-error flag is set and a record is held. `REC_OVER` means both the first-error and second-error flags are set. `REC_SPILL` means only the second-error flag is left after a partial acknowledge. The next state is computed by first applying any acknowledge in that cycle and then applying the incoming error. An error with the first flag clear goes to `REC_HELD` or `REC_OVER` and loads the record. An error with the first flag still set goes to `REC_OVER` and does not touch the record. An acknowledge goes to whichever state matches the flags that remain.

A second two-state machine handles fault injection. `INJ_IDLE` passes write check bits through unchanged. Writing the option register with the force bit set moves it to `INJ_ARMED`. The next memory write in `INJ_ARMED` XORs the stored pattern into its check byte and returns the machine to `INJ_IDLE`.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and `mem_chk_out` equals `mem_chk_in`.
- R2: The option register at error-window offset 0x00 holds the mode in bits [1:0], the force flag in bit 8 and the injection pattern in bits [23:16]. All other bits read zero.
- R3: A correctable pulse in mode 1 or 3, with interrupt-status bit 3 clear, captures its inputs. The address reads at offset 0x18, the syndrome in bits [15:8] of 0x1C (other bits zero), data bits [31:0] at 0x20 and data bits [63:32] at 0x24. Status bit 3 sets on the next clock.
- R4: An uncorrectable pulse under the same conditions fills the record at 0x08, 0x0C, 0x10 and 0x14 with the same layout, and sets status bit 5.
- R5: A pulse of a class whose first-error bit (3 or 5) is already set sets that class's second-error bit (4 or 6) and leaves the record unchanged.
- R6: Correctable and uncorrectable pulses in the same cycle are both captured, each in its own record.
- R7: In modes 0 and 2, error pulses change no flag and no record, and `irq` stays low.
- R8: A write to interrupt-window offset 0x04 clears each status bit written as 1 and leaves the others set. That register reads zero.
- R9: The interrupt-status register sits at interrupt-window offset 0x00. `irq` is high exactly when the mode is 1 or 3 and any of status bits 3 to 6 is set, and it follows the state on the next clock.
- R10: With the force flag set, the next cycle with `mem_wr_fire` high drives `mem_chk_out = mem_chk_in ^ pattern`. The force flag then reads zero and the pattern is kept.
- R11: With the force flag clear, `mem_chk_out` equals `mem_chk_in`.
- R12: Writes to the capture records and to the interrupt-status register are ignored.
- R13: Once a class's first-error bit has been acknowledged, the next error of that class captures a new record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| ce_pulse | input | 1 | Correctable-error pulse from the decoder |
| ue_pulse | input | 1 | Uncorrectable-error pulse from the decoder |
| fault_addr | input | ADDR_W | Failing address |
| fault_data | input | 64 | Read word at the failing address |
| fault_synd | input | 8 | Decoder syndrome |
| mem_wr_fire | input | 1 | A memory write takes place this cycle |
| mem_chk_in | input | 8 | Check byte from the encoder |
| mem_chk_out | output | 8 | Check byte sent to memory |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the decoder pulses last one cycle and that the address, data and syndrome are valid during the pulse. They also assume that register writes are single-cycle strobes, so an acknowledge and an option write are each seen exactly once. The stimulus holds every pulse and write strobe for exactly one clock and changes inputs only away from the sampling edge. It never overlaps an acknowledge with an error of the same class, which keeps every flag transition on a single documented path.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int DATA_W = 64;
    localparam int SYND_W = 8;

    // byte offsets inside the error window
    localparam logic [7:0] OFS_OPT     = 8'h00;
    localparam logic [7:0] OFS_U_ADDR  = 8'h08;
    localparam logic [7:0] OFS_U_STAT  = 8'h0C;
    localparam logic [7:0] OFS_U_DLO   = 8'h10;
    localparam logic [7:0] OFS_U_DHI   = 8'h14;
    localparam logic [7:0] OFS_C_ADDR  = 8'h18;
    localparam logic [7:0] OFS_C_STAT  = 8'h1C;
    localparam logic [7:0] OFS_C_DLO   = 8'h20;
    localparam logic [7:0] OFS_C_DHI   = 8'h24;

    // byte offsets inside the interrupt window
    localparam logic [7:0] OFS_ISTAT   = 8'h00;
    localparam logic [7:0] OFS_IACK    = 8'h04;

    // interrupt status bit positions
    localparam int BIT_CE  = 3;
    localparam int BIT_CE2 = 4;
    localparam int BIT_UE  = 5;
    localparam int BIT_UE2 = 6;

    // class index used by the capture generate loop
    localparam int CLS_UE  = 0;
    localparam int CLS_CE  = 1;
    localparam int N_CLS   = 2;

    typedef enum logic [1:0] {
        REC_CLEAR = 2'd0,
        REC_HELD  = 2'd1,
        REC_OVER  = 2'd2,
        REC_SPILL = 2'd3
    } rec_state_t;

    typedef enum logic {
        INJ_IDLE  = 1'b0,
        INJ_ARMED = 1'b1
    } inj_state_t;

    // modes 1 and 3 have ECC active
    function automatic logic mode_active(input logic [1:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/ecc_cap_record.sv
module ecc_cap_record
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic                evt,
    input  logic                ack_first,
    input  logic                ack_second,
    input  logic [ADDR_W-1:0]   evt_addr,
    input  logic [DATA_W-1:0]   evt_data,
    input  logic [SYND_W-1:0]   evt_synd,
    output logic                first_flag,
    output logic                second_flag,
    output logic [ADDR_W-1:0]   rec_addr,
    output logic [DATA_W-1:0]   rec_data,
    output logic [SYND_W-1:0]   rec_synd
);

    rec_state_t state_q;
    rec_state_t state_d;
    logic       take;
    logic       f_cur;
    logic       s_cur;
    logic       f_nxt;
    logic       s_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REC_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: acknowledge applies first, then the incoming event
    always_comb begin
        f_cur = 1'b0;
        s_cur = 1'b0;
        unique case (state_q)
            REC_CLEAR: begin f_cur = 1'b0; s_cur = 1'b0; end
            REC_HELD:  begin f_cur = 1'b1; s_cur = 1'b0; end
            REC_OVER:  begin f_cur = 1'b1; s_cur = 1'b1; end
            REC_SPILL: begin f_cur = 1'b0; s_cur = 1'b1; end
            default:   begin f_cur = 1'b0; s_cur = 1'b0; end
        endcase
        f_nxt = f_cur & ~ack_first;
        s_nxt = s_cur & ~ack_second;
        take  = 1'b0;
        if (evt && cap_en) begin
            if (!f_nxt) begin
                take  = 1'b1;
                f_nxt = 1'b1;
            end else begin
                s_nxt = 1'b1;
            end
        end
        unique case ({f_nxt, s_nxt})
            2'b00:   state_d = REC_CLEAR;
            2'b10:   state_d = REC_HELD;
            2'b11:   state_d = REC_OVER;
            2'b01:   state_d = REC_SPILL;
            default: state_d = REC_CLEAR;
        endcase
    end

    // captured record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_addr <= '0;
            rec_data <= '0;
            rec_synd <= '0;
        end else if (take) begin
            rec_addr <= evt_addr;
            rec_data <= evt_data;
            rec_synd <= evt_synd;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            REC_CLEAR: begin first_flag = 1'b0; second_flag = 1'b0; end
            REC_HELD:  begin first_flag = 1'b1; second_flag = 1'b0; end
            REC_OVER:  begin first_flag = 1'b1; second_flag = 1'b1; end
            REC_SPILL: begin first_flag = 1'b0; second_flag = 1'b1; end
            default:   begin first_flag = 1'b0; second_flag = 1'b0; end
        endcase
    end

    // R5
    repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_flag && evt && cap_en && !ack_first)
        |=> (second_flag && $stable(rec_addr) && $stable(rec_data) && $stable(rec_synd)));

    // R7
    idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !first_flag && !second_flag) |=> (!first_flag && !second_flag));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_first && !(evt && cap_en)) |=> !first_flag);

    // R13
    refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_flag && evt && cap_en) |=> (first_flag && rec_addr == $past(evt_addr)));

endmodule

// File: rtl/ecc_cap_inject.sv
module ecc_cap_inject
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_we,
    input  logic [1:0]        wr_mode,
    input  logic              wr_force,
    input  logic [SYND_W-1:0] wr_pattern,
    input  logic              mem_wr_fire,
    input  logic [SYND_W-1:0] chk_in,
    output logic [SYND_W-1:0] chk_out,
    output logic [1:0]        mode,
    output logic              force_flag,
    output logic [SYND_W-1:0] pattern
);

    inj_state_t state_q;
    inj_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INJ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // option fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= '0;
            pattern <= '0;
        end else if (opt_we) begin
            mode    <= wr_mode;
            pattern <= wr_pattern;
        end
    end

    // next state: a register write takes priority over a consuming write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INJ_IDLE: begin
                if (opt_we && wr_force) state_d = INJ_ARMED;
            end
            INJ_ARMED: begin
                if (opt_we)           state_d = wr_force ? INJ_ARMED : INJ_IDLE;
                else if (mem_wr_fire) state_d = INJ_IDLE;
            end
            default: state_d = INJ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        force_flag = 1'b0;
        chk_out    = chk_in;
        unique case (state_q)
            INJ_IDLE: begin
                force_flag = 1'b0;
                chk_out    = chk_in;
            end
            INJ_ARMED: begin
                force_flag = 1'b1;
                chk_out    = mem_wr_fire ? (chk_in ^ pattern) : chk_in;
            end
            default: begin
                force_flag = 1'b0;
                chk_out    = chk_in;
            end
        endcase
    end

    // R10
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_flag && mem_wr_fire && !opt_we) |=> (!force_flag && $stable(pattern)));

    // R11
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !force_flag |-> (chk_out == chk_in));

endmodule

// File: rtl/ecc_cap_regmap.sv
module ecc_cap_regmap
    import ecc_cap_pkg::*;
#(
    parameter logic [7:0] ERR_BASE = 8'h00,
    parameter logic [7:0] INT_BASE = 8'h40
) (
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [1:0]        mode,
    input  logic              force_flag,
    input  logic [SYND_W-1:0] pattern,
    input  logic [3:0]        flags,
    input  logic [31:0]       ue_addr,
    input  logic [SYND_W-1:0] ue_synd,
    input  logic [DATA_W-1:0] ue_data,
    input  logic [31:0]       ce_addr,
    input  logic [SYND_W-1:0] ce_synd,
    input  logic [DATA_W-1:0] ce_data,
    output logic              opt_we,
    output logic              ack_we,
    output logic [31:0]       cfg_rdata
);

    localparam logic [7:0] A_OPT    = ERR_BASE + OFS_OPT;
    localparam logic [7:0] A_U_ADDR = ERR_BASE + OFS_U_ADDR;
    localparam logic [7:0] A_U_STAT = ERR_BASE + OFS_U_STAT;
    localparam logic [7:0] A_U_DLO  = ERR_BASE + OFS_U_DLO;
    localparam logic [7:0] A_U_DHI  = ERR_BASE + OFS_U_DHI;
    localparam logic [7:0] A_C_ADDR = ERR_BASE + OFS_C_ADDR;
    localparam logic [7:0] A_C_STAT = ERR_BASE + OFS_C_STAT;
    localparam logic [7:0] A_C_DLO  = ERR_BASE + OFS_C_DLO;
    localparam logic [7:0] A_C_DHI  = ERR_BASE + OFS_C_DHI;
    localparam logic [7:0] A_ISTAT  = INT_BASE + OFS_ISTAT;
    localparam logic [7:0] A_IACK   = INT_BASE + OFS_IACK;

    assign opt_we = cfg_wr && (cfg_addr == A_OPT);
    assign ack_we = cfg_wr && (cfg_addr == A_IACK);

    // flags = {ue2, ue, ce2, ce}
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            A_OPT:    cfg_rdata = {8'h00, pattern, 7'h00, force_flag, 6'h00, mode};
            A_U_ADDR: cfg_rdata = ue_addr;
            A_U_STAT: cfg_rdata = {16'h0000, ue_synd, 8'h00};
            A_U_DLO:  cfg_rdata = ue_data[31:0];
            A_U_DHI:  cfg_rdata = ue_data[63:32];
            A_C_ADDR: cfg_rdata = ce_addr;
            A_C_STAT: cfg_rdata = {16'h0000, ce_synd, 8'h00};
            A_C_DLO:  cfg_rdata = ce_data[31:0];
            A_C_DHI:  cfg_rdata = ce_data[63:32];
            A_ISTAT:  cfg_rdata = {25'h0, flags, 3'b000};
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter logic [7:0] ERR_BASE = 8'h00,
    parameter logic [7:0] INT_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              ce_pulse,
    input  logic              ue_pulse,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic [63:0]       fault_data,
    input  logic [7:0]        fault_synd,
    input  logic              mem_wr_fire,
    input  logic [7:0]        mem_chk_in,
    output logic [7:0]        mem_chk_out,
    output logic              irq
);

    logic                opt_we;
    logic                ack_we;
    logic [1:0]          mode;
    logic                force_flag;
    logic [SYND_W-1:0]   pattern;
    logic                cap_en;
    logic [N_CLS-1:0]    evt_v;
    logic [N_CLS-1:0]    first_v;
    logic [N_CLS-1:0]    second_v;
    logic [ADDR_W-1:0]   raddr_v [N_CLS];
    logic [DATA_W-1:0]   rdata_v [N_CLS];
    logic [SYND_W-1:0]   rsynd_v [N_CLS];
    logic [3:0]          flags;
    logic                unused_wdata;

    assign unused_wdata = ^{cfg_wdata[31:24], cfg_wdata[15:9], cfg_wdata[7], cfg_wdata[2]};

    assign cap_en          = mode_active(mode);
    assign evt_v[CLS_UE]   = ue_pulse;
    assign evt_v[CLS_CE]   = ce_pulse;

    ecc_cap_inject u_inject (
        .clk         (clk),
        .rst_n       (rst_n),
        .opt_we      (opt_we),
        .wr_mode     (cfg_wdata[1:0]),
        .wr_force    (cfg_wdata[8]),
        .wr_pattern  (cfg_wdata[23:16]),
        .mem_wr_fire (mem_wr_fire),
        .chk_in      (mem_chk_in),
        .chk_out     (mem_chk_out),
        .mode        (mode),
        .force_flag  (force_flag),
        .pattern     (pattern)
    );

    for (genvar g = 0; g < N_CLS; g++) begin : g_cls
        localparam int FB = (g == CLS_UE) ? BIT_UE  : BIT_CE;
        localparam int SB = (g == CLS_UE) ? BIT_UE2 : BIT_CE2;

        ecc_cap_record #(.ADDR_W(ADDR_W)) u_rec (
            .clk         (clk),
            .rst_n       (rst_n),
            .cap_en      (cap_en),
            .evt         (evt_v[g]),
            .ack_first   (ack_we && cfg_wdata[FB]),
            .ack_second  (ack_we && cfg_wdata[SB]),
            .evt_addr    (fault_addr),
            .evt_data    (fault_data),
            .evt_synd    (fault_synd),
            .first_flag  (first_v[g]),
            .second_flag (second_v[g]),
            .rec_addr    (raddr_v[g]),
            .rec_data    (rdata_v[g]),
            .rec_synd    (rsynd_v[g])
        );
    end

    assign flags = {second_v[CLS_UE], first_v[CLS_UE], second_v[CLS_CE], first_v[CLS_CE]};

    ecc_cap_regmap #(.ERR_BASE(ERR_BASE), .INT_BASE(INT_BASE)) u_regmap (
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .mode       (mode),
        .force_flag (force_flag),
        .pattern    (pattern),
        .flags      (flags),
        .ue_addr    (32'(raddr_v[CLS_UE])),
        .ue_synd    (rsynd_v[CLS_UE]),
        .ue_data    (rdata_v[CLS_UE]),
        .ce_addr    (32'(raddr_v[CLS_CE])),
        .ce_synd    (rsynd_v[CLS_CE]),
        .ce_data    (rdata_v[CLS_CE]),
        .opt_we     (opt_we),
        .ack_we     (ack_we),
        .cfg_rdata  (cfg_rdata)
    );

    always_comb begin
        irq = cap_en && (|flags);
    end

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|first_v || |second_v));

    // R6
    dual_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_pulse && ue_pulse && cap_en && !ack_we && first_v == '0)
        |=> (first_v == '1));

endmodule

// File: tb/sim_ecc_err_capture.sv
module sim_ecc_err_capture;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] EB = 8'h00;
    localparam logic [7:0] IB = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ce_pulse = 1'b0;
    logic        ue_pulse = 1'b0;
    logic [31:0] fault_addr = '0;
    logic [63:0] fault_data = '0;
    logic [7:0]  fault_synd = '0;
    logic        mem_wr_fire = 1'b0;
    logic [7:0]  mem_chk_in = '0;
    logic [7:0]  mem_chk_out;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit mon_go = 1'b0;

    // scoreboard queues: kind 0 = register read, 1 = irq, 2 = check byte
    int      kind_q[$];
    int      exp_q[$];
    string   tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_err_capture #(.ADDR_W(32), .ERR_BASE(EB), .INT_BASE(IB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ce_pulse(ce_pulse),
        .ue_pulse(ue_pulse), .fault_addr(fault_addr), .fault_data(fault_data),
        .fault_synd(fault_synd), .mem_wr_fire(mem_wr_fire), .mem_chk_in(mem_chk_in),
        .mem_chk_out(mem_chk_out), .irq(irq)
    );

    // monitor: pops one expected item per sampled cycle
    always @(negedge clk) begin
        if (mon_go && kind_q.size() > 0) begin
            int k;
            int e;
            int act;
            string t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (k == 0)      act = int'(cfg_rdata);
            else if (k == 1) act = int'(irq);
            else             act = int'(mem_chk_out);
            checks++;
            if (act != e) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", t, act, e);
            end
        end
    end

    task automatic expect_item(input int k, input logic [7:0] a, input int e, input string t);
        @(posedge clk); #1;
        cfg_addr = a;
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
        mon_go = 1'b1;
        @(posedge clk); #1;
        mon_go = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        expect_item(0, a, int'(e), t);
    endtask

    task automatic irq_is(input bit e, input string t);
        expect_item(1, 8'h00, int'(e), t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic err(input bit ce, input bit ue, input logic [31:0] a,
                       input logic [63:0] d, input logic [7:0] s);
        @(posedge clk); #1;
        ce_pulse = ce; ue_pulse = ue; fault_addr = a; fault_data = d; fault_synd = s;
        @(posedge clk); #1;
        ce_pulse = 1'b0; ue_pulse = 1'b0;
    endtask

    task automatic mem_write(input logic [7:0] cin, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        mem_wr_fire = 1'b1; mem_chk_in = cin;
        kind_q.push_back(2);
        exp_q.push_back(int'(e));
        tag_q.push_back(t);
        mon_go = 1'b1;
        @(posedge clk); #1;
        mem_wr_fire = 1'b0; mon_go = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(EB + 8'h00, 32'h0, "R1 opt");
        rd(EB + 8'h08, 32'h0, "R1 ue addr");
        rd(EB + 8'h1C, 32'h0, "R1 ce stat");
        rd(IB + 8'h00, 32'h0, "R1 int status");
        irq_is(1'b0, "R1 irq");
        mem_write(8'h3C, 8'h3C, "R1 check pass");

        // R7 mode 0 and mode 2 ignore errors
        err(1'b1, 1'b1, 32'h1111_2222, 64'h1, 8'h11);
        rd(IB + 8'h00, 32'h0, "R7 mode0 status");
        rd(EB + 8'h18, 32'h0, "R7 mode0 ce addr");
        wr(EB + 8'h00, 32'h0000_0002);
        err(1'b0, 1'b1, 32'h3333_4444, 64'h2, 8'h22);
        rd(IB + 8'h00, 32'h0, "R7 mode2 status");
        rd(EB + 8'h08, 32'h0, "R7 mode2 ue addr");
        irq_is(1'b0, "R7 mode2 irq");

        // R2 option field layout
        wr(EB + 8'h00, 32'hFFA5_FE01);
        rd(EB + 8'h00, 32'h00A5_0001, "R2 opt readback");

        // R3 first correctable capture
        err(1'b1, 1'b0, 32'h1234_5678, 64'hDEAD_BEEF_CAFE_F00D, 8'h5A);
        rd(EB + 8'h18, 32'h1234_5678, "R3 ce addr");
        rd(EB + 8'h1C, 32'h0000_5A00, "R3 ce syndrome");
        rd(EB + 8'h20, 32'hCAFE_F00D, "R3 ce data lo");
        rd(EB + 8'h24, 32'hDEAD_BEEF, "R3 ce data hi");
        rd(IB + 8'h00, 32'h0000_0008, "R3 status bit3");
        irq_is(1'b1, "R9 irq on ce");

        // R5 second correctable keeps record
        err(1'b1, 1'b0, 32'h9999_0000, 64'h5, 8'h77);
        rd(IB + 8'h00, 32'h0000_0018, "R5 ce overflow");
        rd(EB + 8'h18, 32'h1234_5678, "R5 ce addr kept");
        rd(EB + 8'h1C, 32'h0000_5A00, "R5 ce syndrome kept");

        // R8 selective acknowledge
        wr(IB + 8'h04, 32'h0000_0008);
        rd(IB + 8'h00, 32'h0000_0010, "R8 partial ack");
        irq_is(1'b1, "R9 irq second only");
        rd(IB + 8'h04, 32'h0, "R8 ack reads zero");
        wr(IB + 8'h04, 32'h0000_0010);
        rd(IB + 8'h00, 32'h0, "R8 full ack");
        irq_is(1'b0, "R9 irq cleared");

        // R13 new record after acknowledge
        err(1'b1, 1'b0, 32'hAAAA_0000, 64'h0123_4567_89AB_CDEF, 8'h0F);
        rd(EB + 8'h18, 32'hAAAA_0000, "R13 ce addr refilled");
        rd(EB + 8'h20, 32'h89AB_CDEF, "R13 ce data refilled");
        wr(IB + 8'h04, 32'h0000_0078);

        // R6 and R4 simultaneous classes
        err(1'b1, 1'b1, 32'h0F0F_0F0F, 64'h1122_3344_5566_7788, 8'hC3);
        rd(IB + 8'h00, 32'h0000_0028, "R6 both status bits");
        rd(EB + 8'h08, 32'h0F0F_0F0F, "R4 ue addr");
        rd(EB + 8'h0C, 32'h0000_C300, "R4 ue syndrome");
        rd(EB + 8'h10, 32'h5566_7788, "R4 ue data lo");
        rd(EB + 8'h14, 32'h1122_3344, "R4 ue data hi");
        rd(EB + 8'h18, 32'h0F0F_0F0F, "R6 ce addr");
        err(1'b0, 1'b1, 32'h7777_7777, 64'h9, 8'h01);
        rd(IB + 8'h00, 32'h0000_0068, "R5 ue overflow");
        rd(EB + 8'h08, 32'h0F0F_0F0F, "R5 ue addr kept");

        // R12 capture and status registers are read-only
        wr(EB + 8'h08, 32'hFFFF_FFFF);
        wr(EB + 8'h1C, 32'hFFFF_FFFF);
        wr(IB + 8'h00, 32'h0000_0000);
        rd(EB + 8'h08, 32'h0F0F_0F0F, "R12 ue addr unchanged");
        rd(EB + 8'h1C, 32'h0000_C300, "R12 ce stat unchanged");
        rd(IB + 8'h00, 32'h0000_0068, "R12 status unchanged");

        // R9 mode gating of irq with flags pending
        wr(EB + 8'h00, 32'h00A5_0002);
        irq_is(1'b0, "R9 irq gated by mode");
        wr(EB + 8'h00, 32'h00A5_0003);
        irq_is(1'b1, "R9 irq mode3");
        wr(IB + 8'h04, 32'h0000_0078);
        irq_is(1'b0, "R8 irq after ack all");

        // R10 injection one-shot
        wr(EB + 8'h00, 32'h00A5_0101);
        rd(EB + 8'h00, 32'h00A5_0101, "R10 force armed");
        mem_write(8'h3C, 8'h99, "R10 injected check");
        rd(EB + 8'h00, 32'h00A5_0001, "R10 force cleared pattern kept");
        // R11 no injection once disarmed
        mem_write(8'h3C, 8'h3C, "R11 clean check");
        mem_write(8'hF0, 8'hF0, "R11 clean check 2");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule